// File: doc/BRIEF.md
# Raster-Op Blit Word Datapath

This block is the per-word datapath of a one-bit-per-pixel frame buffer engine. Each cycle it takes a source word and the destination word currently in memory and produces the word to write back. The source is first aligned to the destination's bit position by a funnel shifter. The shifter keeps the previously read source word and picks sixteen bits out of the pair {previous, current}. The aligned source and the destination are then combined under a four-bit raster-operation code. A per-bit write-inhibit mask finally lets chosen destination bits keep their old value.

Configuration is held in four small registers: operating mode with shift amount, raster-op code, write-inhibit mask, and source selection. Each register has its own load strobe and comes out of reset in a plain pass-through state. A source read strobe tells the shifter to capture the current source word. Issuing that strobe once before the first useful word primes the shifter when a left-to-right copy moves pixels toward lower bit offsets. The result output is combinational from the current source and destination words and the registered state. Address generation and memory arbitration sit outside the block.

Top module: `blit_word_path`

## Requirements
- R1: Each configuration field loads on the rising clock edge where its own strobe is high and holds otherwise. Synchronous reset sets mode 3'b111, shift 0, source select 2'b11, raster-op 4'h3 and an all-zero mask. The shifter's held word also resets to zero.
- R2: Mode 3'b100 is block transfer and mode 3'b010 is vector drawing. Mode 3'b111 and every other mode code are normal access.
- R3: In normal access the result is the selected source word with no shift. The raster-op code, the mask and the destination word have no effect.
- R4: The held word loads `src_word` on every edge with `src_vld` high, priming reads included, and holds otherwise. In block transfer the plane source is bits [15:0] of {held, src_word} shifted right by the shift field taken modulo 16, so field bit 4 is ignored. Bit 15 is the leftmost pixel.
- R5: Source select 2'b00 gives all ones. 2'b01 replicates `src_word[0]` over all 16 bits. 2'b11 and 2'b10 give the plane source. The first two bypass the shifter.
- R6: In block transfer and vector drawing, result bit i before masking is rop[{~S[i], ~D[i]}]. So 0 gives zero, 1 gives S AND D, 3 gives S, 5 gives D, 6 gives XOR, 7 gives OR, 8 gives NOR, C gives NOT S and F gives ones.
- R7: In block transfer and vector drawing, a mask bit of 1 returns the destination bit unchanged. A mask of zero writes every bit from the raster-op result.
- R8: In vector drawing the shift is forced to zero while the raster-op and the mask still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Load strobe for mode and shift |
| ctl_mode | input | 3 | Mode code |
| ctl_shift | input | 5 | Shift amount, used modulo 16 |
| rop_we | input | 1 | Load strobe for raster-op code |
| rop_code | input | 4 | Raster-op truth table |
| msk_we | input | 1 | Load strobe for write-inhibit mask |
| msk_bits | input | 16 | Write-inhibit mask, 1 keeps the destination bit |
| smode_we | input | 1 | Load strobe for source select |
| smode_code | input | 2 | Source select |
| src_vld | input | 1 | Source read strobe; captures src_word into the held word |
| src_word | input | 16 | Current source word |
| dst_word | input | 16 | Current destination word |
| res_word | output | 16 | Word to write back |

## Verification
The bench works at the shift boundaries: zero, fifteen, and a value with bit 4 set. A shifter that indexed the pair the wrong way round or honoured bit 4 would return bits from the wrong word. It streams words with and without the read strobe, and checks the result right after reset with no priming read. Those cases expose a held word that is loaded on the wrong strobe or not cleared. Every raster-op code named in the requirements is driven against a fixed S/D pattern, where a swapped truth-table index turns AND into NOR-like output. Masked writes, the normal-mode bypass, vector mode with a nonzero shift field, and unassigned mode codes are also driven. A design that leaked the raster-op or the shift into those paths would alter the word written back.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam int WORD_W = 16;
    localparam int SH_W   = $clog2(WORD_W) + 1;
    localparam int MODE_W = 3;
    localparam int ROP_W  = 4;

    localparam logic [MODE_W-1:0] MODE_VEC = 3'b010;
    localparam logic [MODE_W-1:0] MODE_BLT = 3'b100;
    localparam logic [MODE_W-1:0] MODE_NRM = 3'b111;
    localparam logic [ROP_W-1:0]  ROP_COPY = 4'h3;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        SSEL_ONES  = 2'b00,
        SSEL_REPL  = 2'b01,
        SSEL_RSVD  = 2'b10,
        SSEL_PLANE = 2'b11
    } ssel_e;

    typedef enum logic [1:0] {
        PATH_PASS,
        PATH_VEC,
        PATH_BLT
    } path_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [SH_W-1:0]   shift;
        ssel_e             ssel;
        logic [ROP_W-1:0]  rop;
        word_t             wmask;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        mode:  MODE_NRM,
        shift: '0,
        ssel:  SSEL_PLANE,
        rop:   ROP_COPY,
        wmask: '0
    };

    // Mode decode: unlisted codes fall back to plain access
    function automatic path_e path_of(logic [MODE_W-1:0] m);
        case (m)
            MODE_BLT: return PATH_BLT;
            MODE_VEC: return PATH_VEC;
            default:  return PATH_PASS;
        endcase
    endfunction

    // Truth-table lookup, index formed from inverted source and destination
    function automatic logic rop_bit(logic [ROP_W-1:0] rop, logic s, logic d);
        return rop[{~s, ~d}];
    endfunction

    // Shift amount reduced modulo the word width
    function automatic logic [SH_W-1:0] shift_mod(logic [SH_W-1:0] sh);
        return sh & SH_W'(WORD_W - 1);
    endfunction

    // Pick one word out of the {older, newer} pair
    function automatic word_t funnel(word_t older, word_t newer, logic [SH_W-1:0] sh);
        logic [2*WORD_W-1:0] cat;
        cat = {older, newer} >> sh;
        return cat[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/blit_cfg_regs.sv
module blit_cfg_regs
    import blit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [MODE_W-1:0] ctl_mode,
    input  logic [SH_W-1:0]   ctl_shift,
    input  logic              rop_we,
    input  logic [ROP_W-1:0]  rop_code,
    input  logic              msk_we,
    input  word_t             msk_bits,
    input  logic              smode_we,
    input  logic [1:0]        smode_code,
    output cfg_t              cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RST;
        end else begin
            if (ctl_we) begin
                cfg_q.mode  <= ctl_mode;
                cfg_q.shift <= ctl_shift;
            end
            if (rop_we) begin
                cfg_q.rop <= rop_code;
            end
            if (msk_we) begin
                cfg_q.wmask <= msk_bits;
            end
            if (smode_we) begin
                cfg_q.ssel <= ssel_e'(smode_code);
            end
        end
    end

endmodule

// File: rtl/blit_src_stage.sv
module blit_src_stage
    import blit_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            src_vld,
    input  word_t           src_word,
    input  ssel_e           ssel,
    input  logic [SH_W-1:0] shamt,
    output word_t           prev_q,
    output word_t           s_word
);

    // Held word: captured on every source read, priming reads included
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else if (src_vld) begin
            prev_q <= src_word;
        end
    end

    always_comb begin
        case (ssel)
            SSEL_ONES: s_word = '1;
            SSEL_REPL: s_word = {WORD_W{src_word[0]}};
            default:   s_word = funnel(prev_q, src_word, shamt);
        endcase
    end

endmodule

// File: rtl/blit_rop_unit.sv
module blit_rop_unit
    import blit_pkg::*;
(
    input  path_e            path,
    input  logic [ROP_W-1:0] rop,
    input  word_t            wmask,
    input  word_t            s_word,
    input  word_t            d_word,
    output word_t            res
);

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        logic combined;
        assign combined = rop_bit(rop, s_word[i], d_word[i]);
        assign res[i]   = (path == PATH_PASS) ? s_word[i]
                        : (wmask[i] ? d_word[i] : combined);
    end

endmodule

// File: rtl/blit_word_path.sv
module blit_word_path
    import blit_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_we,
    input  logic [2:0]  ctl_mode,
    input  logic [4:0]  ctl_shift,
    input  logic        rop_we,
    input  logic [3:0]  rop_code,
    input  logic        msk_we,
    input  logic [15:0] msk_bits,
    input  logic        smode_we,
    input  logic [1:0]  smode_code,
    input  logic        src_vld,
    input  logic [15:0] src_word,
    input  logic [15:0] dst_word,
    output logic [15:0] res_word
);

    cfg_t            cfg_q;
    word_t           prev_q;
    word_t           s_word;
    path_e           path;
    logic [SH_W-1:0] shamt;

    blit_cfg_regs u_cfg (
        .clk        (clk),
        .rst        (rst),
        .ctl_we     (ctl_we),
        .ctl_mode   (ctl_mode),
        .ctl_shift  (ctl_shift),
        .rop_we     (rop_we),
        .rop_code   (rop_code),
        .msk_we     (msk_we),
        .msk_bits   (msk_bits),
        .smode_we   (smode_we),
        .smode_code (smode_code),
        .cfg_q      (cfg_q)
    );

    assign path  = path_of(cfg_q.mode);
    // Only block transfer shifts; vector and plain access force zero
    assign shamt = (path == PATH_BLT) ? shift_mod(cfg_q.shift) : '0;

    blit_src_stage u_src (
        .clk      (clk),
        .rst      (rst),
        .src_vld  (src_vld),
        .src_word (src_word),
        .ssel     (cfg_q.ssel),
        .shamt    (shamt),
        .prev_q   (prev_q),
        .s_word   (s_word)
    );

    blit_rop_unit u_rop (
        .path   (path),
        .rop    (cfg_q.rop),
        .wmask  (cfg_q.wmask),
        .s_word (s_word),
        .d_word (dst_word),
        .res    (res_word)
    );

endmodule

// File: rtl/blit_word_path_chk.sv
module blit_word_path_chk
    import blit_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  ctl_we,
    input logic  rop_we,
    input logic  msk_we,
    input logic  smode_we,
    input logic  src_vld,
    input word_t src_word,
    input word_t dst_word,
    input word_t res_word,
    input cfg_t  cfg_q,
    input word_t prev_q
);

    // R1: reset leaves the documented defaults
    p_reset_defaults_r1: assert property (@(posedge clk)
        rst |=> (cfg_q.mode == MODE_NRM && cfg_q.rop == ROP_COPY &&
                 cfg_q.wmask == '0 && cfg_q.ssel == SSEL_PLANE &&
                 cfg_q.shift == '0 && prev_q == '0));

    // R1: configuration holds while no strobe is high
    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !(ctl_we || rop_we || msk_we || smode_we) |=> $stable(cfg_q));

    // R3: plain access with a plane source passes the word unchanged
    p_plain_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (path_of(cfg_q.mode) == PATH_PASS && cfg_q.ssel[1]) |-> res_word == src_word);

    // R4: held word captures on a read strobe
    p_prev_load_r4: assert property (@(posedge clk) disable iff (rst)
        src_vld |=> prev_q == $past(src_word));

    // R4: held word is kept without a read strobe
    p_prev_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !src_vld |=> $stable(prev_q));

    // R5: all-ones source reaches the output in plain access
    p_ones_src_r5: assert property (@(posedge clk) disable iff (rst)
        (path_of(cfg_q.mode) == PATH_PASS && cfg_q.ssel == SSEL_ONES) |-> res_word == '1);

    // R7: inhibited bits keep the destination value
    p_mask_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (path_of(cfg_q.mode) != PATH_PASS) |-> ((res_word ^ dst_word) & cfg_q.wmask) == '0);

endmodule

bind blit_word_path blit_word_path_chk u_chk (.*);

// File: tb/tb_blit_word_path.sv
module tb_blit_word_path;

    localparam int PERIOD = 10;
    localparam int NVEC   = 25;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_we, rop_we, msk_we, smode_we, src_vld;
    logic [2:0]  ctl_mode;
    logic [4:0]  ctl_shift;
    logic [3:0]  rop_code;
    logic [15:0] msk_bits;
    logic [1:0]  smode_code;
    logic [15:0] src_word, dst_word, res_word;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    blit_word_path dut (.*);

    // {req[3:0], mode[2:0], shift[4:0], ssel[1:0], rop[3:0], mask, held, src, dst, expected}
    localparam logic [97:0] VECS [NVEC] = '{
        {4'd3, 3'b111, 5'h00, 2'b11, 4'h0, 16'hFFFF, 16'h0000, 16'h1234, 16'hABCD, 16'h1234}, // R3
        {4'd3, 3'b111, 5'h07, 2'b11, 4'h3, 16'h0000, 16'hFFFF, 16'h00F0, 16'h0000, 16'h00F0}, // R3
        {4'd4, 3'b100, 5'h04, 2'b11, 4'h3, 16'h0000, 16'hABCD, 16'h1234, 16'h0000, 16'hD123}, // R4
        {4'd4, 3'b100, 5'h00, 2'b11, 4'h3, 16'h0000, 16'hFFFF, 16'h5A5A, 16'h0000, 16'h5A5A}, // R4
        {4'd4, 3'b100, 5'h0F, 2'b11, 4'h3, 16'h0000, 16'h8001, 16'h0000, 16'h0000, 16'h0002}, // R4
        {4'd4, 3'b100, 5'h14, 2'b11, 4'h3, 16'h0000, 16'hABCD, 16'h1234, 16'h0000, 16'hD123}, // R4
        {4'd6, 3'b100, 5'h00, 2'b11, 4'h6, 16'h0000, 16'h0000, 16'hF0F0, 16'hFF00, 16'h0FF0}, // R6
        {4'd6, 3'b100, 5'h00, 2'b11, 4'h7, 16'h0000, 16'h0000, 16'hF0F0, 16'hFF00, 16'hFFF0}, // R6
        {4'd6, 3'b100, 5'h00, 2'b11, 4'h8, 16'h0000, 16'h0000, 16'hF0F0, 16'hFF00, 16'h000F}, // R6
        {4'd6, 3'b100, 5'h00, 2'b11, 4'hC, 16'h0000, 16'h0000, 16'hF0F0, 16'hFF00, 16'h0F0F}, // R6
        {4'd6, 3'b100, 5'h00, 2'b11, 4'h1, 16'h0000, 16'h0000, 16'hF0F0, 16'hFF00, 16'hF000}, // R6
        {4'd6, 3'b100, 5'h00, 2'b11, 4'h5, 16'h0000, 16'h0000, 16'hF0F0, 16'hFF00, 16'hFF00}, // R6
        {4'd6, 3'b100, 5'h00, 2'b11, 4'h0, 16'h0000, 16'h0000, 16'hF0F0, 16'hFF00, 16'h0000}, // R6
        {4'd6, 3'b100, 5'h00, 2'b11, 4'hF, 16'h0000, 16'h0000, 16'hF0F0, 16'hFF00, 16'hFFFF}, // R6
        {4'd7, 3'b100, 5'h00, 2'b11, 4'h3, 16'h00FF, 16'h0000, 16'hF0F0, 16'h1234, 16'hF034}, // R7
        {4'd7, 3'b100, 5'h00, 2'b11, 4'h0, 16'hFFFF, 16'h0000, 16'hF0F0, 16'h1234, 16'h1234}, // R7
        {4'd8, 3'b010, 5'h09, 2'b00, 4'h3, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF}, // R8
        {4'd8, 3'b010, 5'h00, 2'b00, 4'h6, 16'hF00F, 16'h0000, 16'h0000, 16'h1234, 16'h1DC4}, // R8
        {4'd8, 3'b010, 5'h08, 2'b11, 4'h3, 16'h0000, 16'hFF00, 16'h00AA, 16'h0000, 16'h00AA}, // R8
        {4'd5, 3'b100, 5'h04, 2'b01, 4'h3, 16'h0000, 16'hABCD, 16'h0001, 16'h0000, 16'hFFFF}, // R5
        {4'd5, 3'b100, 5'h00, 2'b01, 4'h3, 16'h0000, 16'h0000, 16'hFFFE, 16'h0000, 16'h0000}, // R5
        {4'd5, 3'b111, 5'h00, 2'b00, 4'h0, 16'h0000, 16'h0000, 16'h1234, 16'h0000, 16'hFFFF}, // R5
        {4'd2, 3'b000, 5'h00, 2'b11, 4'h0, 16'hFFFF, 16'h0000, 16'h4321, 16'h0000, 16'h4321}, // R2
        {4'd5, 3'b100, 5'h08, 2'b10, 4'h3, 16'h0000, 16'h00FF, 16'hAB00, 16'h0000, 16'hFFAB}, // R5
        {4'd2, 3'b011, 5'h05, 2'b11, 4'hF, 16'h0000, 16'h1111, 16'h2222, 16'h0000, 16'h2222}  // R2
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: res_word=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic cfg_all(input logic [2:0] m, input logic [4:0] sh, input logic [1:0] ss,
                           input logic [3:0] r, input logic [15:0] mk);
        @(negedge clk);
        ctl_mode = m; ctl_shift = sh; smode_code = ss; rop_code = r; msk_bits = mk;
        ctl_we = 1'b1; rop_we = 1'b1; msk_we = 1'b1; smode_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0; rop_we = 1'b0; msk_we = 1'b0; smode_we = 1'b0;
    endtask

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: res_word=%h expected=finish", res_word);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        ctl_we = 0; rop_we = 0; msk_we = 0; smode_we = 0; src_vld = 0;
        ctl_mode = 0; ctl_shift = 0; rop_code = 0; msk_bits = 0; smode_code = 0;
        src_word = 0; dst_word = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state is plain access with plane source
        src_word = 16'h1234; dst_word = 16'hFFFF;
        #1 check("R1 reset passthrough", res_word, 16'h1234);

        // R1: only mode written; copy op and empty mask come from reset
        @(negedge clk);
        ctl_mode = 3'b100; ctl_shift = 5'h00; ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
        #1 check("R1 default rop and mask", res_word, 16'h1234);

        // R4: held word is zero after reset, no priming read issued
        @(negedge clk);
        ctl_shift = 5'h08; ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
        #1 check("R4 held word reset", res_word, 16'h0012);

        // R1: field values without strobes change nothing
        @(negedge clk);
        rop_code = 4'h0; msk_bits = 16'hFFFF; ctl_mode = 3'b111; smode_code = 2'b00;
        @(negedge clk);
        #1 check("R1 hold without strobe", res_word, 16'h0012);

        for (int i = 0; i < NVEC; i++) begin
            logic [97:0] v;
            string tag;
            v = VECS[i];
            tag = $sformatf("R%0d vector %0d", v[97:94], i);
            cfg_all(v[93:91], v[90:86], v[85:84], v[83:80], v[79:64]);
            src_vld = 1'b1; src_word = v[63:48];
            @(negedge clk);
            src_vld = 1'b0; src_word = v[47:32]; dst_word = v[31:16];
            #1 check(tag, res_word, v[15:0]);
        end

        // R4: streaming with a priming read, then a held word without strobe
        cfg_all(3'b100, 5'h04, 2'b11, 4'h3, 16'h0000);
        dst_word = 16'h0000;
        src_vld = 1'b1; src_word = 16'hAAAA;
        @(negedge clk);
        src_word = 16'hBBBB;
        #1 check("R4 stream after prime", res_word, 16'hABBB);
        @(negedge clk);
        src_vld = 1'b0; src_word = 16'hCCCC;
        #1 check("R4 stream second word", res_word, 16'hBCCC);
        @(negedge clk);
        src_word = 16'hDDDD;
        #1 check("R4 held without strobe", res_word, 16'hBDDD);

        // R1: reset mid-run restores plain access
        cfg_all(3'b100, 5'h03, 2'b00, 4'h0, 16'h0F0F);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        src_word = 16'h5555; dst_word = 16'hAAAA;
        #1 check("R1 reset after config", res_word, 16'h5555);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule